// File: doc/BRIEF.md
# Watch Timer with Buzzer Output

This block divides a system clock of 2^22 Hz (nominally 4.19 MHz) down to a periodic timekeeping event. It also drives a buzzer pin with one of four square-wave tones taken from the same divider chain. Each event sets a sticky request flag. The flag is the block's quasi-interrupt request: it holds until software clears it, and the same level can wake the processor from idle. Software counts the ticks and does all calendar arithmetic.

An 8-bit mode register is written through a strobe. It switches the divider on and off and picks between a normal interval of 2^21 clocks (0.5 s) and a fast test interval of 2^14 clocks (about 3.91 ms). It also gates the buzzer and selects its tone. The request flag has its own write strobe. All interval and tap exponents are parameters, so a bench or a variant can shorten the chain.

Top module: `watch_buzz_timer`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears the mode register to 0x00 and the request flag, and holds `buz_o` low. With the mode left at 0x00, no request is raised however long the clock runs.
- R2: Mode bit 0 enables the divider. While that bit is 0 the divider is held at zero. After it is set at edge E0, the count equals the number of clock edges since E0, so a new interval always starts from zero.
- R3: With bit 0 = 1 and mode bit 1 = 0, the request flag rises at the edge 2^NORM_LOG2 clocks after enabling (default 2^21 = 0.5 s at 2^22 Hz).
- R4: With bits 0 and 1 both set, the request flag rises at the edge 2^FAST_LOG2 clocks after enabling (default 2^14, about 3.91 ms).
- R5: A `flag_we` write with `flag_wdata` = 0 clears the request flag. A write with `flag_wdata` = 1 leaves the flag unchanged. The flag stays high until such a clear.
- R6: If an interval event and a clearing write land on the same edge, the flag is set.
- R7: When mode bit 2 is 0, or the divider is off, `buz_o` is low.
- R8: With bits 0 and 2 set, the 2-bit tone field in mode bits 5:4 (value s) selects a square wave on `buz_o` equal to bit (BUZ_LOG2-1-s) of the divider count. This gives a period of 2^(BUZ_LOG2-s) clocks: 2, 4, 8 and 16 kHz for s = 0..3 at the defaults. Bits 3, 6 and 7 have no effect.
- R9: While enabled, interval events repeat every interval, so the flag sets again after being cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 2^22 Hz nominal |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| flag_we | input | 1 | Request flag write strobe |
| flag_wdata | input | 1 | Request flag write data (0 clears) |
| wt_req | output | 1 | Sticky interval request / wake level |
| buz_o | output | 1 | Buzzer tone output |

## Verification
The checker watches several rules on every cycle:
- the divider is cleared whenever it is disabled;
- every interval event is followed by a set flag, and every rise of the flag has an interval event behind it;
- the flag cannot fall without a clearing write;
- the buzzer stays quiet while it is disabled.

Some properties can only be shown by the bench's scenarios, which compare every cycle against a model of elapsed clocks. These are the exact interval lengths in both rates, the tone periods for each selector value, the winner when an event and a clear collide, and the restart of the count after a disable.

// File: rtl/wt_pkg.sv
package wt_pkg;

   // Mode register layout, MSB first.
   typedef struct packed {
      logic [1:0] spare_hi;
      logic [1:0] tone;
      logic       spare_lo;
      logic       buz_en;
      logic       fast;
      logic       div_en;
   } wt_mode_t;

   localparam int unsigned WT_TONES = 4;
   localparam int unsigned WT_MODE_W = 8;

endpackage

// File: rtl/wt_mode_reg.sv
module wt_mode_reg
   import wt_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [WT_MODE_W-1:0] wdata,
   output wt_mode_t             mode_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mode_q <= '0;
      else if (we) mode_q <= wt_mode_t'(wdata);
   end

endmodule

// File: rtl/wt_divider.sv
module wt_divider #(
   parameter int unsigned CNT_W  = 21,
   parameter int unsigned FAST_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             fast,
   output logic [CNT_W-1:0] cnt,
   output logic             tick
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (!en) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

   // Event on the last count of the selected interval.
   always_comb tick = en & (fast ? (&cnt[FAST_W-1:0]) : (&cnt));

endmodule

// File: rtl/wt_req_flag.sv
module wt_req_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr_we,
   input  logic clr_data,
   output logic req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    req <= 1'b0;
      else if (tick)                 req <= 1'b1;
      else if (clr_we && !clr_data)  req <= 1'b0;
   end

endmodule

// File: rtl/wt_tone_sel.sv
module wt_tone_sel
   import wt_pkg::*;
#(
   parameter int unsigned CNT_W    = 21,
   parameter int unsigned BUZ_LOG2 = 11,
   parameter bit          REG_OUT  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [1:0]       tone,
   input  logic             en,
   output logic             buz
);

   localparam int unsigned TOP_TAP = BUZ_LOG2 - 1;

   logic [WT_TONES-1:0] taps;
   logic                raw;

   for (genvar i = 0; i < WT_TONES; i++) begin : g_tap
      assign taps[i] = cnt[TOP_TAP - i];
   end

   assign raw = en & taps[tone];

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) buz <= 1'b0;
         else        buz <= raw;
      end
   end else begin : g_comb
      assign buz = raw;
   end

endmodule

// File: rtl/watch_buzz_timer.sv
module watch_buzz_timer
   import wt_pkg::*;
#(
   parameter int unsigned NORM_LOG2 = 21,
   parameter int unsigned FAST_LOG2 = 14,
   parameter int unsigned BUZ_LOG2  = 11,
   parameter bit          BUZ_REG   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_we,
   input  logic [WT_MODE_W-1:0] mode_wdata,
   input  logic                 flag_we,
   input  logic                 flag_wdata,
   output logic                 wt_req,
   output logic                 buz_o
);

   localparam int unsigned CNT_W = NORM_LOG2;

   if (FAST_LOG2 == 0 || FAST_LOG2 >= NORM_LOG2) begin : g_bad_fast
      $error("FAST_LOG2 must lie between 1 and NORM_LOG2-1");
   end
   if (BUZ_LOG2 < WT_TONES || BUZ_LOG2 > NORM_LOG2) begin : g_bad_buz
      $error("BUZ_LOG2 must lie between WT_TONES and NORM_LOG2");
   end

   wt_mode_t         mode_q;
   logic             div_en;
   logic             buz_en;
   logic [CNT_W-1:0] cnt;
   logic             tick;

   assign div_en = mode_q.div_en;
   assign buz_en = mode_q.buz_en;

   wt_mode_reg u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (mode_we),
      .wdata  (mode_wdata),
      .mode_q (mode_q)
   );

   wt_divider #(.CNT_W(CNT_W), .FAST_W(FAST_LOG2)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (div_en),
      .fast  (mode_q.fast),
      .cnt   (cnt),
      .tick  (tick)
   );

   wt_req_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .clr_we   (flag_we),
      .clr_data (flag_wdata),
      .req      (wt_req)
   );

   wt_tone_sel #(.CNT_W(CNT_W), .BUZ_LOG2(BUZ_LOG2), .REG_OUT(BUZ_REG)) u_tone (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt),
      .tone  (mode_q.tone),
      .en    (buz_en),
      .buz   (buz_o)
   );

endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
   parameter int unsigned CNT_W = 21
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flag_we,
   input logic             flag_wdata,
   input logic             div_en,
   input logic             buz_en,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic             wt_req,
   input logic             buz_o
);

   AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !div_en |=> (cnt == '0));  // R2

   AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> wt_req);  // R6

   AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wt_req) |-> $past(tick));  // R3

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wt_req && !(flag_we && !flag_wdata)) |=> wt_req);  // R5

   AST_BUZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!buz_en && !$past(buz_en)) |-> !buz_o);  // R7

endmodule

bind watch_buzz_timer wt_checker #(.CNT_W(NORM_LOG2)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flag_we    (flag_we),
   .flag_wdata (flag_wdata),
   .div_en     (div_en),
   .buz_en     (buz_en),
   .tick       (tick),
   .cnt        (cnt),
   .wt_req     (wt_req),
   .buz_o      (buz_o)
);

// File: tb/tb_watch_buzz_timer.sv
`timescale 1ns/1ps
module tb_watch_buzz_timer;

   localparam int NORM = 10;
   localparam int FAST = 6;
   localparam int BUZ  = 5;
   localparam int RUN  = 1100;
   localparam int NROWS = 8;
   // Mode vectors: bit0 divider on, bit1 fast, bit2 buzzer on, bits5:4 tone
   localparam logic [7:0] ROWS [NROWS] = '{
      8'h05,   // R3 R8 normal rate, tone 0
      8'h15,   // R8 tone 1
      8'h27,   // R4 R8 fast rate, tone 2
      8'h37,   // R4 R8 tone 3
      8'h03,   // R4 R7 buzzer off
      8'h34,   // R7 divider off, buzzer on
      8'hC9,   // R8 spare bits ignored
      8'h01    // R3 plain normal rate
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_we = 1'b0;
   logic [7:0] mode_wdata = '0;
   logic       flag_we = 1'b0;
   logic       flag_wdata = 1'b0;
   logic       wt_req;
   logic       buz_o;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   watch_buzz_timer #(.NORM_LOG2(NORM), .FAST_LOG2(FAST), .BUZ_LOG2(BUZ), .BUZ_REG(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
      .flag_we(flag_we), .flag_wdata(flag_wdata), .wt_req(wt_req), .buz_o(buz_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Called at a negedge; occupies exactly one rising edge.
   task automatic write_mode(input logic [7:0] v);
      mode_we = 1'b1; mode_wdata = v;
      @(negedge clk);
      mode_we = 1'b0;
   endtask

   task automatic write_flag(input logic v);
      flag_we = 1'b1; flag_wdata = v;
      @(negedge clk);
      flag_we = 1'b0;
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      finish_run();
   end

   initial begin
      int k;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(wt_req == 1'b0 && buz_o == 1'b0, "R1 outputs during reset", {wt_req, buz_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(wt_req == 1'b0 && buz_o == 1'b0, "R1 outputs after reset", {wt_req, buz_o}, 0);
      wait_cycles(RUN);
      check(wt_req == 1'b0, "R1 no request with reset mode", wt_req, 0);
      // R5 writing one to a clear flag does nothing
      write_flag(1'b1);
      check(wt_req == 1'b0, "R5 write one on clear flag", wt_req, 0);

      // Table walk
      for (int r = 0; r < NROWS; r++) begin
         int bad = 0, bad_k = -1, bad_act = 0, bad_exp = 0;
         bit de, fs, be;
         int tap, per;
         de = ROWS[r][0]; fs = ROWS[r][1]; be = ROWS[r][2];
         tap = BUZ - 1 - int'(ROWS[r][5:4]);
         per = fs ? (1 << FAST) : (1 << NORM);
         write_mode(8'h00);
         write_flag(1'b0);
         write_mode(ROWS[r]);
         for (int kk = 0; kk < RUN; kk++) begin
            bit er, eb;
            er = de && (kk >= per);
            eb = de && be && (((kk % (1 << NORM)) >> tap) & 1) != 0;
            if (wt_req !== er || buz_o !== eb) begin
               if (bad == 0) begin
                  bad_k = kk; bad_act = {wt_req, buz_o}; bad_exp = {er, eb};
               end
               bad++;
            end
            @(negedge clk);
         end
         n_checks++;
         if (bad != 0) begin
            n_fail++;
            $display("FAIL R3/R4/R7/R8 row %0d mode %02h cycle %0d: actual {req,buz}=%0d expected %0d",
                     r, ROWS[r], bad_k, bad_act, bad_exp);
         end
      end

      // R5 sticky, write one ignored, write zero clears
      write_mode(8'h00);
      write_flag(1'b0);
      write_mode(8'h03);
      k = 0;
      wait_cycles(70); k = 70;
      check(wt_req == 1'b1, "R4 fast request raised", wt_req, 1);
      write_flag(1'b1); k++;
      check(wt_req == 1'b1, "R5 write one keeps flag", wt_req, 1);
      write_flag(1'b0); k++;
      check(wt_req == 1'b0, "R5 write zero clears flag", wt_req, 0);
      // R9 repeat at the next interval
      wait_cycles(127 - k); k = 127;
      check(wt_req == 1'b0, "R9 no early repeat", wt_req, 0);
      @(negedge clk); k = 128;
      check(wt_req == 1'b1, "R9 repeat at second interval", wt_req, 1);
      write_flag(1'b0); k++;
      check(wt_req == 1'b0, "R5 clear after repeat", wt_req, 0);
      // R6 event and clear on the same edge
      wait_cycles(191 - k); k = 191;
      write_flag(1'b0); k = 192;
      check(wt_req == 1'b1, "R6 set wins over clear", wt_req, 1);

      // R2 disable clears the count; restart is from zero
      wait_cycles(9);
      write_mode(8'h00);
      write_flag(1'b0);
      check(wt_req == 1'b0, "R2 flag cleared with divider off", wt_req, 0);
      write_mode(8'h03);
      wait_cycles(63);
      check(wt_req == 1'b0, "R2 no event before full interval", wt_req, 0);
      @(negedge clk);
      check(wt_req == 1'b1, "R2 event exactly one interval after restart", wt_req, 1);

      // R1 reset in the middle of operation
      write_mode(8'h37);
      wait_cycles(20);
      rst_n = 1'b0;
      #1;
      check(wt_req == 1'b0 && buz_o == 1'b0, "R1 asynchronous reset", {wt_req, buz_o}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      wait_cycles(200);
      check(wt_req == 1'b0 && buz_o == 1'b0, "R1 mode cleared by reset", {wt_req, buz_o}, 0);

      finish_run();
   end

endmodule